// File: doc/BRIEF.md
# Interrupt Distributor Register Block

This block collects interrupt lines from peripherals, gives each one a fixed interrupt ID, and raises a pending-interrupt line toward each of up to eight CPUs. Software sets it up through a 32-bit register port. The control register turns forwarding on and off. A read-only type word reports how many IDs the block supports. Enable state is packed one bit per ID, with separate banks for setting and for clearing. Each ID has a byte that selects which CPUs it targets. Each ID also has a two-bit field that picks level or edge detection. Edge interrupts are caught in sticky pending bits, and software clears those through a dedicated bank.

The expected bring-up order is as follows. While forwarding is off, software programs the enables, targets and sensitivity. It then sets the control bit. Every other register refuses writes while forwarding is on, so the setup cannot change under live traffic. External input j is interrupt ID 32+j. IDs 0 to 31 have no input line. Register reads are combinational from the address. Writes take effect at the clock edge on which the write strobe is high.

Top module: `irq_distributor`

## Requirements
- R1: The control word is at byte offset 0x000. Its bit 0 turns on forwarding, resets to 0, and reads back as written. While bit 0 is 0, every cpuIrq line is low one cycle later.
- R2: While forwarding is on, writes to any offset other than 0x000 leave all enables, targets, sensitivity fields and pending bits unchanged.
- R3: Offset 0x004 reads NUM_IDS/32-1 in bits [4:0], which is 3 for 128 IDs, and 0 in all other bits. Writes to it have no effect.
- R4: Writing 1 to bit (N mod 32) of the word at 0x100+4*(N div 32) enables ID N. Writing 0 has no effect. A read returns the enable state.
- R5: Writing 1 to bit (N mod 32) of the word at 0x180+4*(N div 32) disables ID N. Writing 0 has no effect. A read returns the enable state.
- R6: The target byte of ID N is lane (N mod 4) of the word at 0x800+4*(N div 4), where lane 0 is bits [7:0]. Bit k of that byte routes ID N to CPU k, and the byte reads back as written.
- R7: The sensitivity field of ID N is bits [2*(N mod 16)+1 : 2*(N mod 16)] of the word at 0xC00+4*(N div 16). Its upper bit set to 1 selects edge and set to 0 selects level. Its lower bit always reads 0. For IDs 0 to 15 the upper bit reads 0 and ignores writes.
- R8: Input irqIn[j] drives ID 32+j. For a level ID, the pending state follows the input.
- R9: For an edge ID, a rising input edge sets a sticky pending bit that stays set after the input falls. Pending state reads at 0x280+4*(N div 32), bit (N mod 32). Writing 1 there clears the sticky bit.
- R10: One cycle after the condition holds, cpuIrq[k] is high when forwarding is on and some ID is enabled, pending, and has bit k set in its target byte.
- R11: Reads of unmapped offsets, and of bank words beyond the supported IDs, return 0. Writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 12 | Register byte offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, combinational from regAddr |
| irqIn | input | NUM_IDS-32 | Peripheral interrupt inputs; bit j is ID 32+j |
| cpuIrq | output | NUM_CPUS | Pending-interrupt line per CPU |

## Verification
The bench targets the write lock. It tries clear-enable and pending-clear writes while forwarding is on. A design without the lock would drop the live interrupt or lose its sticky pending bit. The bench writes all ones to the sensitivity word of the software IDs and expects zeros back, so a design that lets bit 0 or the software IDs' upper bit be written shows up at once. For edge IDs it sends a one-cycle pulse and reads the pending bank after the pulse has ended, which exposes a design that only follows the level. It also writes zeros to the set and clear banks and checks that no enable bit moves. Finally, it routes one ID to two CPUs at once, so a design that decodes the wrong byte lane or target bit raises the wrong lines.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;
  localparam int WORD_IDX_W = 8;

  typedef enum logic [2:0] {
    RD_NONE, RD_CTRL, RD_TYPE, RD_ENABLE, RD_PEND, RD_TARGET, RD_CFG
  } rdSel_e;

  // strobes from the decoder to the storage; write strobes already lock-gated
  typedef struct packed {
    logic                  setEnWr;
    logic                  clrEnWr;
    logic                  clrPendWr;
    logic                  tgtWr;
    logic                  cfgWr;
    rdSel_e                rdSel;
    logic [WORD_IDX_W-1:0] wordIdx;
  } regStrobe_t;
endpackage

// File: rtl/irq_dist_ctrl.sv
module irq_dist_ctrl
  import irq_dist_pkg::*;
#(
  parameter int NUM_IDS = 128
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWe,
  input  logic [11:0] regAddr,
  input  logic       regWdata0,
  output logic       distEn,
  output regStrobe_t strobe
);
  localparam int EN_WORDS  = NUM_IDS / 32;
  localparam int TGT_WORDS = NUM_IDS / 4;
  localparam int CFG_WORDS = NUM_IDS / 16;

  logic hitCtrl, hitType, hitSetEn, hitClrEn, hitPend, hitTgt, hitCfg, wrOk;
  logic unusedAddrLow;
  assign unusedAddrLow = ^regAddr[1:0];

  always_comb begin
    hitCtrl  = (regAddr[11:2] == 10'd0);
    hitType  = (regAddr[11:2] == 10'd1);
    hitSetEn = (regAddr[11:7] == 5'h02) && (int'(regAddr[6:2]) < EN_WORDS);
    hitClrEn = (regAddr[11:7] == 5'h03) && (int'(regAddr[6:2]) < EN_WORDS);
    hitPend  = (regAddr[11:7] == 5'h05) && (int'(regAddr[6:2]) < EN_WORDS);
    hitTgt   = (regAddr[11:10] == 2'b10) && (int'(regAddr[9:2]) < TGT_WORDS);
    hitCfg   = (regAddr[11:8] == 4'hC) && (int'(regAddr[7:2]) < CFG_WORDS);
  end

  // R2: every non-control write is refused while forwarding is on
  assign wrOk = regWe && !distEn;

  always_comb begin
    strobe           = '0;
    strobe.rdSel     = RD_NONE;
    strobe.setEnWr   = wrOk && hitSetEn;
    strobe.clrEnWr   = wrOk && hitClrEn;
    strobe.clrPendWr = wrOk && hitPend;
    strobe.tgtWr     = wrOk && hitTgt;
    strobe.cfgWr     = wrOk && hitCfg;
    if (hitCtrl)                          strobe.rdSel = RD_CTRL;
    else if (hitType)                     strobe.rdSel = RD_TYPE;
    else if (hitSetEn || hitClrEn)        strobe.rdSel = RD_ENABLE;
    else if (hitPend)                     strobe.rdSel = RD_PEND;
    else if (hitTgt)                      strobe.rdSel = RD_TARGET;
    else if (hitCfg)                      strobe.rdSel = RD_CFG;
    if (hitTgt)      strobe.wordIdx = regAddr[9:2];
    else if (hitCfg) strobe.wordIdx = WORD_IDX_W'(regAddr[7:2]);
    else             strobe.wordIdx = WORD_IDX_W'(regAddr[6:2]);
  end

  // R1: forwarding enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  distEn <= 1'b0;
    else if (regWe && hitCtrl)  distEn <= regWdata0;
  end

  // R2: a write strobe never leaves the decoder while forwarding is on
  p_no_strobe_locked_r2: assert property (@(posedge clk) disable iff (!rstN)
    distEn |-> !(strobe.setEnWr || strobe.clrEnWr || strobe.clrPendWr || strobe.tgtWr || strobe.cfgWr));
endmodule

// File: rtl/irq_dist_datapath.sv
module irq_dist_datapath
  import irq_dist_pkg::*;
#(
  parameter int NUM_IDS  = 128,
  parameter int NUM_CPUS = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  regStrobe_t             strobe,
  input  logic                   distEn,
  input  logic [31:0]            regWdata,
  input  logic [NUM_IDS-33:0]    irqIn,
  output logic [31:0]            regRdata,
  output logic [NUM_CPUS-1:0]    cpuIrq
);
  localparam int EN_WORDS = NUM_IDS / 32;
  localparam int SW_IDS   = 16;
  localparam int FIRST_EXT = 32;

  logic [NUM_IDS-1:0] enableBits, edgeCfg, pendVec, stickyVec, riseVec;
  logic [NUM_CPUS-1:0][NUM_IDS-1:0] tgtCol;
  logic [NUM_CPUS-1:0][7:0] unusedTgtRd;
  logic [7:0] tgtByte [NUM_IDS];
  logic [NUM_CPUS-1:0] hit;
  int idxW;
  assign idxW = int'(strobe.wordIdx);
  assign unusedTgtRd = '0;

  for (genvar id = 0; id < NUM_IDS; id++) begin : g_id
    localparam int EN_W = id / 32;
    localparam int EN_B = id % 32;
    localparam int TG_W = id / 4;
    localparam int TG_L = id % 4;
    localparam int CF_W = id / 16;
    localparam int CF_B = 2 * (id % 16) + 1;

    logic enQ;
    logic [NUM_CPUS-1:0] tgtQ;

    // R4 / R5: set and clear banks share one bit layout
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) enQ <= 1'b0;
      else if (strobe.setEnWr && idxW == EN_W && regWdata[EN_B]) enQ <= 1'b1;
      else if (strobe.clrEnWr && idxW == EN_W && regWdata[EN_B]) enQ <= 1'b0;
    end
    assign enableBits[id] = enQ;

    // R6: one target byte per ID
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) tgtQ <= '0;
      else if (strobe.tgtWr && idxW == TG_W) tgtQ <= regWdata[8*TG_L +: NUM_CPUS];
    end
    assign tgtByte[id] = 8'(tgtQ);
    for (genvar k = 0; k < NUM_CPUS; k++) begin : g_cpu
      assign tgtCol[k][id] = tgtQ[k];
    end

    // R7: sensitivity bit, fixed to level for software IDs
    if (id < SW_IDS) begin : g_sw
      assign edgeCfg[id] = 1'b0;
    end else begin : g_cfg
      logic edgeQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) edgeQ <= 1'b0;
        else if (strobe.cfgWr && idxW == CF_W) edgeQ <= regWdata[CF_B];
      end
      assign edgeCfg[id] = edgeQ;
    end

    // R8 / R9: pending capture for IDs that own an input line
    if (id < FIRST_EXT) begin : g_noline
      assign riseVec[id]   = 1'b0;
      assign stickyVec[id] = 1'b0;
      assign pendVec[id]   = 1'b0;
    end else begin : g_line
      logic prevQ, stickyQ, lineIn;
      assign lineIn = irqIn[id-FIRST_EXT];
      assign riseVec[id] = edgeCfg[id] && lineIn && !prevQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          prevQ   <= 1'b0;
          stickyQ <= 1'b0;
        end else begin
          prevQ <= lineIn;
          if (riseVec[id]) stickyQ <= 1'b1;
          else if (strobe.clrPendWr && idxW == EN_W && regWdata[EN_B]) stickyQ <= 1'b0;
        end
      end
      assign stickyVec[id] = stickyQ;
      assign pendVec[id]   = edgeCfg[id] ? stickyQ : lineIn;
    end
  end

  // R10: per-CPU forwarding, registered
  always_comb begin
    for (int k = 0; k < NUM_CPUS; k++) hit[k] = |(enableBits & pendVec & tgtCol[k]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cpuIrq <= '0;
    else       cpuIrq <= distEn ? hit : '0;
  end

  // read mux; R3 type word, R11 unmapped reads zero
  always_comb begin
    regRdata = '0;
    case (strobe.rdSel)
      RD_CTRL:   regRdata[0] = distEn;
      RD_TYPE:   regRdata[4:0] = 5'(EN_WORDS - 1);
      RD_ENABLE: regRdata = enableBits[idxW*32 +: 32];
      RD_PEND:   regRdata = pendVec[idxW*32 +: 32];
      RD_TARGET: for (int l = 0; l < 4; l++) regRdata[8*l +: 8] = tgtByte[idxW*4 + l];
      RD_CFG:    for (int f = 0; f < 16; f++) regRdata[2*f+1] = edgeCfg[idxW*16 + f];
      default:   regRdata = '0;
    endcase
  end

  // R2: locked configuration holds across the cycle
  p_lock_enable_r2: assert property (@(posedge clk) disable iff (!rstN)
    distEn |=> $stable(enableBits));
  p_lock_target_r2: assert property (@(posedge clk) disable iff (!rstN)
    distEn |=> $stable(tgtCol));
  p_lock_cfg_r2: assert property (@(posedge clk) disable iff (!rstN)
    distEn |=> $stable(edgeCfg));
  // R1: outputs quiet while forwarding is off
  p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !distEn |=> (cpuIrq == '0));
  // R9: a rising edge on an edge ID latches pending
  p_edge_sets_r9: assert property (@(posedge clk) disable iff (!rstN)
    (|riseVec) |=> ((stickyVec & $past(riseVec)) == $past(riseVec)));
  // R9: sticky bits drop only through the clear bank
  p_sticky_holds_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.clrPendWr |=> ((stickyVec & $past(stickyVec)) == $past(stickyVec)));
endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
  import irq_dist_pkg::*;
#(
  parameter int NUM_IDS  = 128,
  parameter int NUM_CPUS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWe,
  input  logic [11:0]         regAddr,
  input  logic [31:0]         regWdata,
  output logic [31:0]         regRdata,
  input  logic [NUM_IDS-33:0] irqIn,
  output logic [NUM_CPUS-1:0] cpuIrq
);
  regStrobe_t strobe;
  logic distEn;

  irq_dist_ctrl #(.NUM_IDS(NUM_IDS)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata0(regWdata[0]), .distEn(distEn), .strobe(strobe)
  );

  irq_dist_datapath #(.NUM_IDS(NUM_IDS), .NUM_CPUS(NUM_CPUS)) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .distEn(distEn),
    .regWdata(regWdata), .irqIn(irqIn), .regRdata(regRdata), .cpuIrq(cpuIrq)
  );
endmodule

// File: tb/irq_distributor_bench.sv
module irq_distributor_bench;
  localparam int NUM_IDS  = 128;
  localparam int NUM_CPUS = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [NUM_IDS-33:0] irqIn = '0;
  logic [NUM_CPUS-1:0] cpuIrq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_distributor #(.NUM_IDS(NUM_IDS), .NUM_CPUS(NUM_CPUS)) u_irq_distributor (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .irqIn(irqIn), .cpuIrq(cpuIrq)
  );

  typedef struct packed {
    logic [11:0] wAddr;
    logic [31:0] wData;
    logic [11:0] rAddr;
    logic [31:0] expVal;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{12'h100, 32'h0000_0001, 12'h100, 32'h0000_0001, 8'd4},  // R4 set ID0
    '{12'h108, 32'h0000_1000, 12'h108, 32'h0000_1000, 8'd4},  // R4 set ID76
    '{12'h108, 32'h0000_0000, 12'h108, 32'h0000_1000, 8'd4},  // R4 zero write no effect
    '{12'h188, 32'h0000_1000, 12'h108, 32'h0000_0000, 8'd5},  // R5 clear ID76
    '{12'h180, 32'h0000_0000, 12'h180, 32'h0000_0001, 8'd5},  // R5 zero write, read state
    '{12'h84C, 32'h0102_0408, 12'h84C, 32'h0102_0408, 8'd6},  // R6 target lanes
    '{12'hC10, 32'hFFFF_FFFF, 12'hC10, 32'hAAAA_AAAA, 8'd7},  // R7 bit0 reserved
    '{12'hC00, 32'hFFFF_FFFF, 12'hC00, 32'h0000_0000, 8'd7},  // R7 software IDs fixed
    '{12'hC04, 32'hFFFF_FFFF, 12'hC04, 32'hAAAA_AAAA, 8'd7},  // R7 IDs 16..31
    '{12'h004, 32'hFFFF_FFFF, 12'h004, 32'h0000_0003, 8'd3},  // R3 type word
    '{12'h300, 32'h0000_1234, 12'h300, 32'h0000_0000, 8'd11}, // R11 unmapped
    '{12'h110, 32'hFFFF_FFFF, 12'h110, 32'h0000_0000, 8'd11}  // R11 beyond last bank word
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] expVal);
    checks++;
    if (got !== expVal) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, expVal);
    end
  endtask

  task automatic wrReg(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0; regWdata = '0;
  endtask

  task automatic rdReg(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic rdCheck(input string tag, input logic [11:0] a, input logic [31:0] expVal);
    logic [31:0] v;
    rdReg(a, v);
    check(tag, v, expVal);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // reset state: R1
    rdCheck("R1 ctrl reset", 12'h000, 32'h0);
    rdCheck("R4 enable reset", 12'h108, 32'h0);
    check("R1 cpuIrq reset", 32'(cpuIrq), 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      wrReg(VECS[i].wAddr, VECS[i].wData);
      rdCheck($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].rAddr, VECS[i].expVal);
    end

    // R8 level ID40 (input 8) routed to CPU0
    wrReg(12'h104, 32'h0000_0100);
    wrReg(12'h828, 32'h0000_0001);
    wrReg(12'h000, 32'h1);
    rdCheck("R1 ctrl readback", 12'h000, 32'h1);
    irqIn[8] = 1'b1; settle();
    check("R10 level forwarded", 32'(cpuIrq), 32'h01);
    rdCheck("R8 level pending", 12'h284, 32'h0000_0100);
    irqIn[8] = 1'b0; settle();
    check("R8 level drops", 32'(cpuIrq), 32'h0);
    rdCheck("R8 pending follows", 12'h284, 32'h0);

    // R2 lock while enabled
    wrReg(12'h184, 32'h0000_0100);
    rdCheck("R2 clear-enable locked", 12'h104, 32'h0000_0100);
    irqIn[8] = 1'b1; settle();
    check("R2 still forwarded", 32'(cpuIrq), 32'h01);
    wrReg(12'h000, 32'h0); settle();
    check("R1 disabled quiet", 32'(cpuIrq), 32'h0);
    irqIn[8] = 1'b0;

    // R9 edge ID77 (input 45), target CPU2
    wrReg(12'h108, 32'h0000_2000);
    wrReg(12'h000, 32'h1);
    @(negedge clk); irqIn[45] = 1'b1;
    @(negedge clk); irqIn[45] = 1'b0;
    settle();
    check("R9 edge forwarded", 32'(cpuIrq), 32'h04);
    rdCheck("R9 sticky pending", 12'h288, 32'h0000_2000);
    wrReg(12'h288, 32'h0000_2000);
    rdCheck("R2 pending clear locked", 12'h288, 32'h0000_2000);
    wrReg(12'h000, 32'h0);
    wrReg(12'h288, 32'h0000_2000);
    rdCheck("R9 pending cleared", 12'h288, 32'h0);
    wrReg(12'h000, 32'h1); settle();
    check("R9 nothing after clear", 32'(cpuIrq), 32'h0);

    // R6 two targets for ID40
    wrReg(12'h000, 32'h0);
    wrReg(12'h828, 32'h0000_0081);
    wrReg(12'h000, 32'h1);
    irqIn[8] = 1'b1; settle();
    check("R6 two targets", 32'(cpuIrq), 32'h81);

    // R5 clear-enable stops forwarding
    wrReg(12'h000, 32'h0);
    wrReg(12'h184, 32'h0000_0100);
    wrReg(12'h000, 32'h1); settle();
    check("R5 disabled ID quiet", 32'(cpuIrq), 32'h0);
    irqIn[8] = 1'b0;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule